// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous, byte-writable memory with its own cycle decoder. Every control input is taken on the rising clock edge. Two address strobes start new cycles: a processor-side strobe and a controller-side strobe. An advance input steps a two-bit burst offset, and three chip enables decide whether the device takes part at all. A global write, a write enable and one write enable per byte decide the direction of each beat. Between strobes the block either continues a burst at the next address or suspends at the current one. The burst follows linear or interleaved order, chosen by a static order input.

Read data is staged through an output register, so it reaches the data bus one clock after the array is addressed. The data bus is represented as separate input, output and drive-enable ports, to be joined at a tri-state pad outside the block. An active-low output enable gates the drive-enable without passing through any register. The array is a small parameterized memory: by default 256 words of four 9-bit bytes.

Top module: `pburst_sram`

## Requirements
- R1: The device counts as enabled only when `en1_n`=0, `en2`=1 and `en3_n`=0. Any of the following deselects it for a single cycle: the controller strobe with `en1_n`=1, or either strobe with `en2`=0 or `en3_n`=1. A read issued before the deselect still appears after the next edge. From the edge after that, `dq_oe` stays low, and advance cycles do nothing until a new start.
- R2: When `strb_p_n`=0, `en1_n`=1 and `strb_c_n`=1, the processor strobe is ignored. The cycle acts as a plain continue or suspend of the burst in progress.
- R3: A cycle started by the processor strobe on an enabled device is always a read at `addr`. The write inputs have no effect, and memory is left unchanged.
- R4: A cycle started by the controller strobe (with the processor strobe not taking effect) on an enabled device accesses `addr`. It is a write when a write is requested (R5), and a read otherwise.
- R5: A write is requested when `gwr_n`=0 or when `wr_n`=0 with at least one `bwe_n` bit low. `gwr_n`=0 writes all bytes whatever `bwe_n` holds. Otherwise only byte b is written, bits [9b+8:9b] of `dq_i`, for each b with `bwe_n[b]`=0. With `wr_n`=0 and every `bwe_n` bit high, the cycle is a read.
- R6: With `order_il`=0, beat k of a burst started at address A uses the upper address bits of A. Its low two bits are (A[1:0]+k) mod 4.
- R7: With `order_il`=1, beat k of a burst started at address A uses the upper address bits of A. Its low two bits are A[1:0] xor k.
- R8: With both strobes inactive (R2 counts as inactive), `adv_n`=0 moves the burst to the next beat and `adv_n`=1 repeats the current address. Each beat is a read or a write according to the write inputs of that cycle.
- R9: Read data for an access taken at clock edge n appears on `dq_o`, with `dq_oe` high, after edge n+1.
- R10: `oe_n`=1 forces `dq_oe` low at once, without waiting for a clock edge. `oe_n`=0 restores the drive of held read data at once.
- R11: Writes use the `dq_i` value taken on the same edge. The block does not drive the bus for a write access.
- R12: While `rst_n` is low and after it is released, the device is deselected and `dq_oe` is low until a read has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Start address taken with a strobe |
| strb_p_n | input | 1 | Processor-side address strobe, active low |
| strb_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Primary chip enable, active low |
| en2 | input | 1 | Expansion enable, active high |
| en3_n | input | 1 | Expansion enable, active low |
| gwr_n | input | 1 | Write all bytes, active low |
| wr_n | input | 1 | Byte-masked write enable, active low |
| bwe_n | input | NBYTES | Per-byte write enables, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | NBYTES*BYTE_W | Write data from the bus |
| dq_o | output | NBYTES*BYTE_W | Read data from the output register |
| dq_oe | output | 1 | Bus drive enable for `dq_o` |

## Verification
The assertions check five things on every edge. The output enable always gates the drive. A deselect always clears the selected state and any pending read. A processor start on an enabled device always queues a read from offset zero. An ignored processor strobe advances the burst offset by exactly one. A suspend freezes both the start address and the offset. Some behaviours show only in the bench's scenarios, which compare the bus against a reference array it keeps itself: the actual beat order in both burst modes from every start address, the byte merging of masked and global writes, the one-cycle read latency, and the fact that a processor start leaves memory untouched.

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     strb_p_n,
  input  logic                     strb_c_n,
  input  logic                     adv_n,
  input  logic                     en1_n,
  input  logic                     en2,
  input  logic                     en3_n,
  input  logic                     gwr_n,
  input  logic                     wr_n,
  input  logic [NBYTES-1:0]        bwe_n,
  input  logic                     order_il,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] dq_i,
  output logic [NBYTES*BYTE_W-1:0] dq_o,
  output logic                     dq_oe
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;
  logic              q_vld;
  logic [DATA_W-1:0] q_reg;

  wire chip_en = !en1_n && en2 && !en3_n;
  wire p_start = !strb_p_n && !en1_n;
  wire c_start = !strb_c_n && !p_start;
  wire strobe  = p_start || c_start;
  wire begin_c = strobe && chip_en;

  wire [NBYTES-1:0] wmask = !gwr_n ? {NBYTES{1'b1}} :
                            (!wr_n ? ~bwe_n : {NBYTES{1'b0}});
  wire wreq = |wmask;

  wire [1:0]        cnt_nxt  = strobe ? 2'd0 : (adv_n ? cnt : cnt + 2'd1);
  wire [ADDR_W-1:0] base_nxt = strobe ? addr : base;
  wire [1:0]        lo       = order_il ? (base_nxt[1:0] ^ cnt_nxt)
                                        : (base_nxt[1:0] + cnt_nxt);
  wire [ADDR_W-1:0] acc_addr = {base_nxt[ADDR_W-1:2], lo};

  wire access = begin_c || (!strobe && active);
  wire wr_now = access && wreq && !p_start;
  wire rd_now = access && !wr_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base    <= '0;
      cnt     <= 2'd0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      q_vld   <= 1'b0;
    end else begin
      if (strobe) active <= chip_en;
      if (access) begin
        base <= base_nxt;
        cnt  <= cnt_nxt;
      end
      rd_pend <= rd_now;
      rd_addr <= acc_addr;
      q_vld   <= rd_pend;
    end
  end

  always_ff @(posedge clk)
    if (rd_pend) q_reg <= mem[rd_addr];

  always_ff @(posedge clk)
    if (wr_now)
      for (int b = 0; b < NBYTES; b++)
        if (wmask[b]) mem[acc_addr][b*BYTE_W +: BYTE_W] <= dq_i[b*BYTE_W +: BYTE_W];

  assign dq_o  = q_reg;
  assign dq_oe = !oe_n && q_vld;
endmodule

module pburst_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb_p_n,
  input logic              strb_c_n,
  input logic              adv_n,
  input logic              en1_n,
  input logic              en2,
  input logic              en3_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              active,
  input logic              rd_pend,
  input logic [1:0]        cnt,
  input logic [ADDR_W-1:0] base
);
  wire p_take = !strb_p_n && !en1_n;
  wire quiet  = !p_take && strb_c_n;

  a_r10_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ((p_take || !strb_c_n) && (en1_n || !en2 || en3_n)) |=> (!active && !rd_pend));

  a_r3_p_read: assert property (@(posedge clk) disable iff (!rst_n)
    (p_take && en2 && !en3_n) |=> (rd_pend && active && cnt == 2'd0));

  a_r2_p_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_p_n && en1_n && strb_c_n && !adv_n && active) |=> (active && cnt == $past(cnt) + 2'd1));

  a_r8_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && adv_n) |=> ($stable(cnt) && $stable(base)));

  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dq_oe && !active));
endmodule

bind pburst_sram pburst_sram_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
  .adv_n(adv_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .active(active), .rd_pend(rd_pend), .cnt(cnt), .base(base)
);

// File: tb/sim_pburst_sram.sv
`timescale 1ns/1ps
module sim_pburst_sram;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, strb_p_n, strb_c_n, adv_n, en1_n, en2, en3_n;
  logic          gwr_n, wr_n, order_il, oe_n, dq_oe;
  logic [AW-1:0] addr;
  logic [NB-1:0] bwe_n;
  logic [DW-1:0] dq_i, dq_o;

  pburst_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
    .adv_n(adv_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .gwr_n(gwr_n),
    .wr_n(wr_n), .bwe_n(bwe_n), .order_il(order_il), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  logic [DW-1:0] ref_mem [1 << AW];
  int n_chk = 0;
  int n_fail = 0;
  bit lv = 0, nv = 0;
  logic [DW-1:0] ld = '0, nd = '0;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return {4'(a + s), 32'(a * 32'h01020409 ^ s * 32'h9E3779B1)};
  endfunction

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] a, input int k, input bit il);
    logic [1:0] lo;
    lo = il ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k));
    return {a[AW-1:2], lo};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    strb_p_n = 1; strb_c_n = 1; adv_n = 1; en1_n = 0; en2 = 1; en3_n = 0;
    gwr_n = 1; wr_n = 1; bwe_n = '1; dq_i = '0;
  endtask

  task automatic step(input string rq);
    @(posedge clk);
    #1;
    chk(dq_oe == (lv && !oe_n), rq, 64'(dq_oe), 64'(lv && !oe_n));
    if (lv && !oe_n) chk(dq_o == ld, rq, 64'(dq_o), 64'(ld));
    lv = nv; ld = nd; nv = 0;
    @(negedge clk);
  endtask

  task automatic desel(input string rq);
    idle(); strb_c_n = 0; en1_n = 1; nv = 0;
    step(rq);
    idle();
    step(rq);
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input bit il, input int s);
    order_il = il;
    for (int k = 0; k < 4; k++) begin
      idle();
      if (k == 0) begin strb_c_n = 0; addr = a; end
      else adv_n = 0;
      wr_n = 0; bwe_n = '0;
      dq_i = pat(beat(a, k, il), s);
      ref_mem[beat(a, k, il)] = dq_i;
      nv = 0;
      step(k == 0 ? "R4" : (il ? "R7" : "R6"));
    end
    desel("R11");
  endtask

  task automatic rd_burst(input logic [AW-1:0] a, input bit il, input bit use_p);
    order_il = il;
    for (int k = 0; k < 4; k++) begin
      idle();
      if (k == 0) begin
        addr = a;
        if (use_p) strb_p_n = 0; else strb_c_n = 0;
      end else adv_n = 0;
      nv = 1; nd = ref_mem[beat(a, k, il)];
      step(k == 0 ? "R9" : (il ? "R7" : "R6"));
    end
    desel("R1");
  endtask

  task automatic rd_one(input logic [AW-1:0] a, input string rq);
    idle(); strb_c_n = 0; addr = a; nv = 1; nd = ref_mem[a];
    step(rq);
    desel(rq);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(); addr = '0; order_il = 0; oe_n = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(dq_oe == 1'b0, "R12", 64'(dq_oe), 64'd0);
    @(negedge clk);
    rst_n = 1;
    step("R12");
    step("R12");

    for (int b = 0; b < 64; b++) wr_burst(AW'(b * 4), b[0], 0);
    wr_burst(8'h81, 1, 1);
    wr_burst(8'hC6, 0, 2);
    for (int a = 0; a < 256; a++) rd_burst(AW'(a), a[2], a[0]);

    // R5: every byte mask through the write enable
    for (int m = 0; m < 16; m++) begin
      logic [AW-1:0] wa;
      logic [DW-1:0] d;
      wa = AW'(8'h40 + m);
      idle(); strb_c_n = 0; addr = wa; wr_n = 0; bwe_n = ~4'(m);
      d = pat(wa, 7); dq_i = d;
      if (m == 0) begin nv = 1; nd = ref_mem[wa]; end
      else nv = 0;
      for (int b = 0; b < NB; b++)
        if (m[b]) ref_mem[wa][b*BW +: BW] = d[b*BW +: BW];
      step("R5");
      desel("R5");
      rd_one(wa, "R5");
    end
    // R5: global write overrides byte enables
    idle(); strb_c_n = 0; addr = 8'h60; gwr_n = 0; wr_n = 1; bwe_n = 4'b1010;
    dq_i = pat(8'h60, 11); ref_mem[8'h60] = dq_i; nv = 0;
    step("R5");
    desel("R5");
    rd_one(8'h60, "R5");

    // R3: processor start ignores write inputs
    idle(); strb_p_n = 0; addr = 8'h10; gwr_n = 0; wr_n = 0; bwe_n = '0;
    dq_i = pat(8'h10, 13); nv = 1; nd = ref_mem[8'h10];
    step("R3");
    desel("R3");
    rd_one(8'h10, "R3");

    // R2: ignored processor strobe continues the burst
    order_il = 0;
    idle(); strb_p_n = 0; addr = 8'h22; nv = 1; nd = ref_mem[8'h22];
    step("R2");
    idle(); strb_p_n = 0; en1_n = 1; adv_n = 0; nv = 1; nd = ref_mem[8'h23];
    step("R2");
    idle(); strb_p_n = 0; en1_n = 1; adv_n = 1; nv = 1; nd = ref_mem[8'h23];
    step("R2");
    idle(); adv_n = 0; nv = 1; nd = ref_mem[8'h20];
    step("R2");
    desel("R2");

    // R8: suspend repeats the current address, linear wrap
    idle(); strb_c_n = 0; addr = 8'h33; nv = 1; nd = ref_mem[8'h33];
    step("R8");
    idle(); nv = 1; nd = ref_mem[8'h33];
    step("R8");
    idle(); adv_n = 0; nv = 1; nd = ref_mem[8'h30];
    step("R8");
    idle(); nv = 1; nd = ref_mem[8'h30];
    step("R8");
    desel("R8");

    // R1: deselect via second and third enables, advance has no effect after
    idle(); strb_c_n = 0; addr = 8'h05; nv = 1; nd = ref_mem[8'h05];
    step("R1");
    idle(); strb_p_n = 0; en2 = 0; nv = 0;
    step("R1");
    idle(); adv_n = 0;
    step("R1");
    idle(); adv_n = 0;
    step("R1");
    idle(); strb_p_n = 0; addr = 8'h06; nv = 1; nd = ref_mem[8'h06];
    step("R1");
    idle(); strb_c_n = 0; en3_n = 1; nv = 0;
    step("R1");
    idle(); adv_n = 0;
    step("R1");
    idle();
    step("R1");

    // R11: write beat inside a read burst; bus idle after the write
    order_il = 1;
    idle(); strb_c_n = 0; addr = 8'h44; nv = 1; nd = ref_mem[8'h44];
    step("R11");
    idle(); adv_n = 0; gwr_n = 0; dq_i = pat(8'h45, 3); ref_mem[8'h45] = dq_i; nv = 0;
    step("R11");
    idle(); nv = 1; nd = ref_mem[8'h45];
    step("R11");
    idle(); adv_n = 0; nv = 1; nd = ref_mem[8'h46];
    step("R8");
    desel("R11");

    // R10: output enable acts without a clock edge
    order_il = 0;
    idle(); strb_c_n = 0; addr = 8'h07; nv = 1; nd = ref_mem[8'h07];
    step("R10");
    idle(); nv = 1; nd = ref_mem[8'h07];
    step("R10");
    #0.5 oe_n = 1;
    #0.1 chk(dq_oe == 1'b0, "R10", 64'(dq_oe), 64'd0);
    #0.2 oe_n = 0;
    #0.1 chk(dq_oe == 1'b1, "R10", 64'(dq_oe), 64'd1);
    chk(dq_o == ref_mem[8'h07], "R10", 64'(dq_o), 64'(ref_mem[8'h07]));
    @(negedge clk);
    desel("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule